// File: doc/BRIEF.md
# Parity-Retransmission Hybrid ARQ Transmit Controller

This block is the transmit side of a stop-and-wait hybrid ARQ link that uses incremental redundancy. A 16-bit message is taken in over a ready/valid handshake. The block sends it as a 24-bit frame: the message followed by an 8-bit CRC check field. In the same cycle it derives a 16-bit parity block from the message with an invertible linear map and holds it in a local buffer. The parity block is not transmitted at this point.

When the receiver reports a bad frame with NAK, the block sends the parity block. This frame is wrapped in its own CRC and has the same 24-bit length as a data frame. Further NAKs make the block alternate between the data frame and the parity frame. Because the map is invertible, the receiver can recover the message from a clean parity frame alone. It can also combine a stored copy of one frame with a received copy of the other to correct errors.

ACK frees the buffer and returns the block to idle. A receiver that stays silent for a programmable number of cycles is handled as if it had sent a NAK. A retry counter limits the number of retransmissions. When the limit is passed, the block drops the message and pulses a fail flag.

The controller has five states:
- IDLE: ready for a message.
- SEND_DATA: drives the data frame.
- WAIT_FB: waits for feedback after a data frame.
- SEND_PARITY: drives the parity frame.
- WAIT_FB2: waits for feedback after a parity frame.

Its transitions are:
- IDLE→SEND_DATA on accept.
- SEND_DATA→WAIT_FB and SEND_PARITY→WAIT_FB2 unconditionally.
- WAIT_FB→SEND_PARITY and WAIT_FB2→SEND_DATA on NAK or timeout.
- Either wait state→IDLE on ACK, or on NAK/timeout once the retry limit is reached.

Top module: `harq_tx_top`

## Requirements
- R1: `msg_ready` is high only in IDLE. A `msg_valid` pulse seen while busy has no effect: later frames still carry the accepted message.
- R2: In the cycle after a message is accepted, `tx_valid` is high for exactly one cycle. `tx_is_parity` is 0. `tx_frame` is {D[15:0], CRC8(D)}, where the payload occupies bits 23:8. CRC8 uses polynomial x^8+x^2+x+1 (0x07), starts from zero, and takes message bits MSB first with no reflection.
- R3: The parity block is P = D ^ rotl(D,1) ^ rotl(D,3), computed on 16 bits. After the first NAK the block sends {P, CRC8(P)} with `tx_is_parity` = 1 for one cycle.
- R4: Each further NAK alternates the frame: data, then parity, then data, and so on. Each frame follows its NAK by one cycle.
- R5: ACK in either wait state returns the block to IDLE with no further frame. If ACK and NAK arrive in the same cycle, ACK wins.
- R6: If no feedback arrives for `fb_timeout` cycles after a frame, the block acts as on a NAK. The next frame then appears `fb_timeout`+1 cycles after the previous one. Values 0 and 1 both give one wait cycle.
- R7: After MAX_RETX retransmissions (default 8, so 9 frames in total), the next NAK or timeout drops the message. `fail` is then high for one cycle while `msg_ready` is high.
- R8: After reset, `msg_ready` = 1, `tx_valid` = 0 and `fail` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message offered |
| msg_data | input | 16 | Message bits D |
| msg_ready | output | 1 | Block is idle and takes a message |
| ack | input | 1 | Positive feedback from the receiver |
| nak | input | 1 | Negative feedback from the receiver |
| fb_timeout | input | 16 | Feedback wait limit in cycles |
| tx_valid | output | 1 | Frame present on `tx_frame` this cycle |
| tx_frame | output | 24 | Payload (bits 23:8) and CRC (bits 7:0) |
| tx_is_parity | output | 1 | Frame carries the parity block |
| fail | output | 1 | One-cycle pulse when a message is dropped |

## Verification
The assertions assume that ACK and NAK are asserted only while the block waits for feedback. They also assume that `fb_timeout` does not change while a message is in flight. The properties that map feedback to the next frame rely on this. The directed tasks raise feedback only after they have seen a frame and before the next one appears. They set `fb_timeout` only while the block is idle. The one exception is a deliberate `msg_valid` pulse driven during a wait, which checks that a busy block ignores new messages.

// File: rtl/harq_pkg.sv
package harq_pkg;

    typedef enum logic [2:0] {
        IDLE        = 3'd0,
        SEND_DATA   = 3'd1,
        WAIT_FB     = 3'd2,
        SEND_PARITY = 3'd3,
        WAIT_FB2    = 3'd4
    } harq_state_t;

endpackage

// File: rtl/harq_crc8.sv
module harq_crc8 #(
    parameter int          DATA_W = 16,
    parameter int          CRC_W  = 8,
    parameter logic [7:0]  POLY   = 8'h07
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data_in[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ POLY[CRC_W-1:0];
        end
        crc_out = c;
    end
endmodule

// File: rtl/harq_parity.sv
module harq_parity #(
    parameter int DATA_W = 16,
    parameter int ROT_A  = 1,
    parameter int ROT_B  = 3
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] par_out
);
    logic [DATA_W-1:0] rot_a, rot_b;

    assign rot_a   = (data_in << ROT_A) | (data_in >> (DATA_W - ROT_A));
    assign rot_b   = (data_in << ROT_B) | (data_in >> (DATA_W - ROT_B));
    assign par_out = data_in ^ rot_a ^ rot_b;
endmodule

// File: rtl/harq_fb_timer.sv
module harq_fb_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMR_W-1:0] limit,
    output logic             expire
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expire)   cnt <= cnt + 1'b1;
    end

    assign expire = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
endmodule

// File: rtl/harq_retry.sv
module harq_retry #(
    parameter int MAX_RETX = 8,
    localparam int CNT_W   = $clog2(MAX_RETX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_max
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end

    assign at_max = (cnt == CNT_W'(MAX_RETX));
endmodule

// File: rtl/harq_tx_top.sv
module harq_tx_top
    import harq_pkg::*;
#(
    parameter int         MSG_W    = 16,
    parameter int         CRC_W    = 8,
    parameter logic [7:0] CRC_POLY = 8'h07,
    parameter int         ROT_A    = 1,
    parameter int         ROT_B    = 3,
    parameter int         MAX_RETX = 8,
    parameter int         TMR_W    = 16,
    localparam int        FRAME_W  = MSG_W + CRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid,
    input  logic [MSG_W-1:0]   msg_data,
    output logic               msg_ready,
    input  logic               ack,
    input  logic               nak,
    input  logic [TMR_W-1:0]   fb_timeout,
    output logic               tx_valid,
    output logic [FRAME_W-1:0] tx_frame,
    output logic               tx_is_parity,
    output logic               fail
);
    harq_state_t       state, state_nx;
    logic [MSG_W-1:0]  data_q, par_q, par_d;
    logic [CRC_W-1:0]  crc_data, crc_par;
    logic              fail_q;
    logic              waiting, expire, at_max, retry_ev, accept;

    harq_parity #(.DATA_W(MSG_W), .ROT_A(ROT_A), .ROT_B(ROT_B)) u_par (
        .data_in(msg_data), .par_out(par_d)
    );
    harq_crc8 #(.DATA_W(MSG_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc_d (
        .data_in(data_q), .crc_out(crc_data)
    );
    harq_crc8 #(.DATA_W(MSG_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc_p (
        .data_in(par_q), .crc_out(crc_par)
    );

    assign waiting  = (state == WAIT_FB) || (state == WAIT_FB2);
    assign accept   = (state == IDLE) && msg_valid;
    assign retry_ev = waiting && !ack && (nak || expire);

    harq_fb_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(waiting), .limit(fb_timeout), .expire(expire)
    );
    harq_retry #(.MAX_RETX(MAX_RETX)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(retry_ev && !at_max), .at_max(at_max)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            IDLE:        if (msg_valid) state_nx = SEND_DATA;
            SEND_DATA:   state_nx = WAIT_FB;
            SEND_PARITY: state_nx = WAIT_FB2;
            WAIT_FB: begin
                if (ack)           state_nx = IDLE;
                else if (retry_ev) state_nx = at_max ? IDLE : SEND_PARITY;
            end
            WAIT_FB2: begin
                if (ack)           state_nx = IDLE;
                else if (retry_ev) state_nx = at_max ? IDLE : SEND_DATA;
            end
            default:     state_nx = IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= IDLE;
            fail_q <= 1'b0;
            data_q <= '0;
            par_q  <= '0;
        end else begin
            state  <= state_nx;
            fail_q <= retry_ev && at_max;
            if (accept) begin
                data_q <= msg_data;
                par_q  <= par_d;
            end
        end
    end

    always_comb begin
        msg_ready    = 1'b0;
        tx_valid     = 1'b0;
        tx_is_parity = 1'b0;
        tx_frame     = '0;
        unique case (state)
            IDLE:        msg_ready = 1'b1;
            SEND_DATA: begin
                tx_valid = 1'b1;
                tx_frame = {data_q, crc_data};
            end
            SEND_PARITY: begin
                tx_valid     = 1'b1;
                tx_is_parity = 1'b1;
                tx_frame     = {par_q, crc_par};
            end
            WAIT_FB, WAIT_FB2: ;
            default: ;
        endcase
        fail = fail_q;
    end
endmodule

// File: rtl/harq_tx_chk.sv
module harq_tx_chk #(
    parameter int MSG_W   = 16,
    parameter int FRAME_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic [MSG_W-1:0]   msg_data,
    input logic               msg_ready,
    input logic               ack,
    input logic               nak,
    input logic               tx_valid,
    input logic [FRAME_W-1:0] tx_frame,
    input logic               tx_is_parity,
    input logic               fail
);
    logic [MSG_W-1:0] seen_data;

    function automatic logic [MSG_W-1:0] mix(input logic [MSG_W-1:0] d);
        logic [MSG_W-1:0] r;
        r = d;
        for (int i = 0; i < MSG_W; i++) r[(i + 1) % MSG_W] = d[i];
        mix = d ^ r;
        for (int i = 0; i < MSG_W; i++) r[(i + 3) % MSG_W] = d[i];
        mix = mix ^ r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) seen_data <= '0;
        else if (tx_valid && !tx_is_parity) seen_data <= tx_frame[FRAME_W-1 -: MSG_W];
    end

    p_ready_no_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready |-> !tx_valid);

    p_accept_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> (tx_valid && !tx_is_parity
                                      && tx_frame[FRAME_W-1 -: MSG_W] == $past(msg_data)));

    p_single_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    p_parity_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_is_parity) |-> (tx_frame[FRAME_W-1 -: MSG_W] == mix(seen_data)));

    p_nak_resend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_ready && !tx_valid && nak && !ack) |=> (tx_valid || fail));

    p_ack_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_ready && !tx_valid && ack) |=> (msg_ready && !tx_valid && !fail));

    p_fail_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (msg_ready && !tx_valid));

    p_fail_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);
endmodule

bind harq_tx_top harq_tx_chk #(.MSG_W(MSG_W), .FRAME_W(FRAME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_ready(msg_ready), .ack(ack), .nak(nak), .tx_valid(tx_valid),
    .tx_frame(tx_frame), .tx_is_parity(tx_is_parity), .fail(fail)
);

// File: tb/sim_harq_tx_top.sv
module sim_harq_tx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [15:0] msg_data = '0;
    logic        msg_ready;
    logic        ack = 1'b0;
    logic        nak = 1'b0;
    logic [15:0] fb_timeout = 16'd1000;
    logic        tx_valid;
    logic [23:0] tx_frame;
    logic        tx_is_parity;
    logic        fail;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    harq_tx_top u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_data(msg_data),
        .msg_ready(msg_ready), .ack(ack), .nak(nak), .fb_timeout(fb_timeout),
        .tx_valid(tx_valid), .tx_frame(tx_frame), .tx_is_parity(tx_is_parity),
        .fail(fail)
    );

    function automatic logic [7:0] ref_crc(input logic [15:0] d);
        logic [7:0] c;
        logic       b;
        c = 8'h00;
        for (int i = 15; i >= 0; i--) begin
            b = c[7] ^ d[i];
            c = c << 1;
            if (b) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_par(input logic [15:0] d);
        return d ^ {d[14:0], d[15]} ^ {d[12:0], d[15:13]};
    endfunction

    function automatic logic [23:0] data_frame(input logic [15:0] d);
        return {d, ref_crc(d)};
    endfunction

    function automatic logic [23:0] par_frame(input logic [15:0] d);
        return {ref_par(d), ref_crc(ref_par(d))};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic offer(input logic [15:0] d);
        @(negedge clk);
        chk("R1 ready before offer", 32'(msg_ready), 32'd1);
        msg_valid = 1'b1;
        msg_data  = d;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic expect_frame(input string req, input logic par, input logic [23:0] f);
        int n = 0;
        while (!tx_valid && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " frame valid"}, 32'(tx_valid), 32'd1);
        chk({req, " parity flag"}, 32'(tx_is_parity), 32'(par));
        chk({req, " frame bits"}, 32'(tx_frame), 32'(f));
    endtask

    task automatic feedback(input logic a, input logic n);
        @(negedge clk);
        ack = a;
        nak = n;
        @(negedge clk);
        ack = 1'b0;
        nak = 1'b0;
    endtask

    task automatic t_reset;
        chk("R8 reset ready", 32'(msg_ready), 32'd1);
        chk("R8 reset tx_valid", 32'(tx_valid), 32'd0);
        chk("R8 reset fail", 32'(fail), 32'd0);
    endtask

    task automatic t_clean(input logic [15:0] d);
        offer(d);
        chk("R2 sent next cycle", 32'(tx_valid), 32'd1);
        expect_frame("R2", 1'b0, data_frame(d));
        @(negedge clk);
        chk("R2 one-cycle frame", 32'(tx_valid), 32'd0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R5 ack to idle", 32'(msg_ready), 32'd1);
        @(negedge clk);
        chk("R5 no frame after ack", 32'(tx_valid), 32'd0);
    endtask

    task automatic t_alternate(input logic [15:0] d);
        offer(d);
        expect_frame("R2 first", 1'b0, data_frame(d));
        feedback(1'b0, 1'b1);
        chk("R3 parity follows nak", 32'(tx_valid), 32'd1);
        expect_frame("R3", 1'b1, par_frame(d));
        feedback(1'b0, 1'b1);
        expect_frame("R4 data again", 1'b0, data_frame(d));
        feedback(1'b0, 1'b1);
        expect_frame("R4 parity again", 1'b1, par_frame(d));
        feedback(1'b1, 1'b0);
        chk("R5 ack from parity wait", 32'(msg_ready), 32'd1);
    endtask

    task automatic t_busy_ignore(input logic [15:0] a, input logic [15:0] b);
        offer(a);
        expect_frame("R1 first", 1'b0, data_frame(a));
        @(negedge clk);
        chk("R1 busy not ready", 32'(msg_ready), 32'd0);
        msg_valid = 1'b1;
        msg_data  = b;
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R1 no frame from busy offer", 32'(tx_valid), 32'd0);
        feedback(1'b0, 1'b1);
        expect_frame("R1 parity of first msg", 1'b1, par_frame(a));
        feedback(1'b0, 1'b1);
        expect_frame("R1 data of first msg", 1'b0, data_frame(a));
        feedback(1'b1, 1'b0);
    endtask

    task automatic t_timeout(input logic [15:0] d);
        int gap = 0;
        fb_timeout = 16'd5;
        offer(d);
        expect_frame("R6 first", 1'b0, data_frame(d));
        do begin
            @(negedge clk);
            gap++;
        end while (!tx_valid && gap < 100);
        chk("R6 timeout gap", 32'(gap), 32'd6);
        expect_frame("R6 parity on timeout", 1'b1, par_frame(d));
        feedback(1'b1, 1'b0);
        chk("R6 idle after ack", 32'(msg_ready), 32'd1);
        fb_timeout = 16'd1000;
    endtask

    task automatic t_limit(input logic [15:0] d);
        offer(d);
        for (int i = 0; i < 9; i++) begin
            if (i % 2 == 0) expect_frame("R7 data retry", 1'b0, data_frame(d));
            else            expect_frame("R7 parity retry", 1'b1, par_frame(d));
            feedback(1'b0, 1'b1);
        end
        chk("R7 fail pulse", 32'(fail), 32'd1);
        chk("R7 idle on drop", 32'(msg_ready), 32'd1);
        chk("R7 no tenth frame", 32'(tx_valid), 32'd0);
        @(negedge clk);
        chk("R7 fail one cycle", 32'(fail), 32'd0);
    endtask

    task automatic t_ack_wins(input logic [15:0] d);
        offer(d);
        expect_frame("R5 first", 1'b0, data_frame(d));
        feedback(1'b1, 1'b1);
        chk("R5 ack beats nak ready", 32'(msg_ready), 32'd1);
        chk("R5 ack beats nak no frame", 32'(tx_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean(16'h0000);
        t_clean(16'hFFFF);
        t_clean(16'h8001);
        t_alternate(16'hA5A5);
        t_alternate(16'h0001);
        t_busy_ignore(16'h1234, 16'hBEEF);
        t_timeout(16'h8000);
        t_limit(16'h5A0F);
        t_ack_wins(16'hC3C3);
        t_clean(16'h7E81);
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule